// File: doc/BRIEF.md
# Vector Prefix Predicate Mask Unit

This unit looks at the first word of a 64-bit instruction, the 32-bit prefix, and decides whether it carries the vector extension. For a vector prefix it collects the scattered remap bits into one 24-bit field. It also expands the 4-bit predicate code in the top of that field into one enable bit per vector element. A code can take its enables from one of three fixed integer registers, either directly or inverted. It can instead take them from one chosen flag of a per-element condition field, either on set or on clear. One code enables every element, and one code is reserved and flags an illegal instruction.

Words arrive on a valid/ready stream, and results leave on another valid/ready stream with one register stage in between. Back-pressure rules:
- The unit accepts a word whenever its output register is empty or is being drained in the same cycle (`in_ready = !out_valid || out_ready`).
- A result that is held with `out_ready` low keeps all of its fields stable until it is taken.

The register and condition inputs are sampled in the same cycle as the prefix word.

Top module: `vpm_unit`

## Requirements
- R1: A synchronous active-high reset clears `out_valid`, `out_is_vec` and `out_illegal`. Prefix bits are numbered MSB-first, so prefix bit k is `in_prefix[31-k]`.
- R2: A word is a vector prefix only when prefix bits 0:5 equal 1 (`in_prefix[31:26] == 6'b000001`) and prefix bits 7 and 9 (`in_prefix[24]`, `in_prefix[22]`) are both 1.
- R3: For a vector prefix, `out_remap[23]` = prefix bit 6, `out_remap[22]` = prefix bit 8, and `out_remap[21:0]` = prefix bits 10..31 (`in_prefix[21:0]`). The predicate code is `out_remap[23:20]`.
- R4: For a word that is not a vector prefix, `out_enable` is all ones, `out_remap` is zero, and both flags are low.
- R5: Code 0000 sets `out_illegal` and drives `out_enable` to zero.
- R6: Code 0001 enables every element.
- R7: Codes 0010/0011 select register 3, 0100/0101 select register 10 and 0110/0111 select register 30. Element i follows bit i (LSB = bit 0) of that register for the even code and its inverse for the odd code.
- R8: Codes 1xxx use condition field i (`in_cr[4*i+3:4*i]`, packed {LT,GT,EQ,UN} with LT at bit 3) for element i. Codes 100x pick LT, 101x GT, 110x EQ and 111x UN. The even code enables on a set flag and the odd code on a clear flag.
- R9: A word accepted at a clock edge appears on the outputs with `out_valid` high right after that edge. With no new word and the output drained, `out_valid` falls at the next edge.
- R10: While `out_valid` is high and `out_ready` is low, `in_ready` is low and every output field holds its value. An empty output register always has `in_ready` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Prefix word present |
| in_ready | output | 1 | Unit can accept a word |
| in_prefix | input | 32 | Prefix word, bit 0 of the prefix at `[31]` |
| in_reg3 | input | 64 | Integer register 3 value |
| in_reg10 | input | 64 | Integer register 10 value |
| in_reg30 | input | 64 | Integer register 30 value |
| in_cr | input | 4*N | Condition fields, field i for element i |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_enable | output | N | Per-element enable vector |
| out_remap | output | 24 | Gathered remap field |
| out_is_vec | output | 1 | Word is a vector prefix |
| out_illegal | output | 1 | Reserved predicate code seen |

## Verification
The assertions assume that the consumer obeys the stream rules and that `in_valid` is not raised while reset is high. The bench changes inputs only on falling edges and keeps `out_ready` high except in the back-pressure scenario. The checks on held outputs also assume that no stray handshake occurs while `out_ready` is low. The bench therefore holds a second word on the input across the stalled cycles, so the stall is seen both from the producer side and from the consumer side.

// File: rtl/vpm_pkg.sv
package vpm_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned RM_W   = 24;
  localparam int unsigned CODE_W = 4;
  localparam int unsigned CRF_W  = 4;
  localparam int unsigned REG_W  = 64;
  localparam logic [5:0]  OPC_WIDE = 6'd1;

  typedef struct packed {
    logic            is_vec;
    logic [RM_W-1:0] remap;
  } pfx_info_t;
endpackage

// File: rtl/vpm_prefix_detect.sv
module vpm_prefix_detect
  import vpm_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output pfx_info_t         info
);
  // prefix bit k sits at word[WORD_W-1-k]
  logic opc_ok, marks_ok;

  always_comb begin
    opc_ok   = (word[WORD_W-1 -: 6] == OPC_WIDE);
    marks_ok = word[WORD_W-1-7] & word[WORD_W-1-9];
    info.is_vec = opc_ok & marks_ok;
    if (info.is_vec)
      info.remap = {word[WORD_W-1-6], word[WORD_W-1-8], word[RM_W-3:0]};
    else
      info.remap = '0;
  end
endmodule

// File: rtl/vpm_mask_gen.sv
module vpm_mask_gen
  import vpm_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic               is_vec,
  input  logic [CODE_W-1:0]  code,
  input  logic [REG_W-1:0]   reg3,
  input  logic [REG_W-1:0]   reg10,
  input  logic [REG_W-1:0]   reg30,
  input  logic [CRF_W*N-1:0] cr,
  output logic [N-1:0]       enable,
  output logic               illegal
);
  logic [1:0]   sel;
  logic         inv;
  logic [N-1:0] gpr_bit;
  logic [N-1:0] crf_bit;

  assign sel     = code[2:1];
  assign inv     = code[0];
  assign illegal = is_vec & (code == '0);

  for (genvar i = 0; i < N; i++) begin : g_elem
    always_comb begin
      case (sel)
        2'b01:   gpr_bit[i] = reg3[i];
        2'b10:   gpr_bit[i] = reg10[i];
        default: gpr_bit[i] = reg30[i];
      endcase
      case (sel)
        2'b00:   crf_bit[i] = cr[CRF_W*i+3];
        2'b01:   crf_bit[i] = cr[CRF_W*i+2];
        2'b10:   crf_bit[i] = cr[CRF_W*i+1];
        default: crf_bit[i] = cr[CRF_W*i];
      endcase
      if (!is_vec)
        enable[i] = 1'b1;
      else if (code[3])
        enable[i] = crf_bit[i] ^ inv;
      else if (sel == 2'b00)
        enable[i] = inv;
      else
        enable[i] = gpr_bit[i] ^ inv;
    end
  end
endmodule

// File: rtl/vpm_unit.sv
module vpm_unit
  import vpm_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [31:0]        in_prefix,
  input  logic [63:0]        in_reg3,
  input  logic [63:0]        in_reg10,
  input  logic [63:0]        in_reg30,
  input  logic [4*N-1:0]     in_cr,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [N-1:0]       out_enable,
  output logic [23:0]        out_remap,
  output logic               out_is_vec,
  output logic               out_illegal
);
  pfx_info_t    info;
  logic [N-1:0] en_nxt;
  logic         ill_nxt;

  vpm_prefix_detect u_detect (
    .word (in_prefix),
    .info (info)
  );

  vpm_mask_gen #(.N(N)) u_mask (
    .is_vec  (info.is_vec),
    .code    (info.remap[RM_W-1 -: CODE_W]),
    .reg3    (in_reg3),
    .reg10   (in_reg10),
    .reg30   (in_reg30),
    .cr      (in_cr),
    .enable  (en_nxt),
    .illegal (ill_nxt)
  );

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_is_vec  <= 1'b0;
      out_illegal <= 1'b0;
      out_enable  <= '1;
      out_remap   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_is_vec  <= info.is_vec;
        out_illegal <= ill_nxt;
        out_enable  <= ill_nxt ? '0 : en_nxt;
        out_remap   <= info.remap;
      end
    end
  end
endmodule

// File: rtl/vpm_unit_chk.sv
module vpm_unit_chk #(
  parameter int unsigned N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [N-1:0] out_enable,
  input logic [23:0]  out_remap,
  input logic         out_is_vec,
  input logic         out_illegal
);
  // R9
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_enable) &&
      $stable(out_remap) && $stable(out_is_vec) && $stable(out_illegal));

  // R10
  empty_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

  // R4
  nonvec_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_is_vec |-> (&out_enable) && out_remap == '0 && !out_illegal);

  // R5
  illegal_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_illegal |-> out_is_vec && out_enable == '0 && out_remap[23:20] == 4'b0000);

  // R6
  unmasked_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_is_vec && out_remap[23:20] == 4'b0001 |-> &out_enable);
endmodule

bind vpm_unit vpm_unit_chk #(.N(N)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_enable  (out_enable),
  .out_remap   (out_remap),
  .out_is_vec  (out_is_vec),
  .out_illegal (out_illegal)
);

// File: tb/tb_vpm_unit.sv
module tb_vpm_unit;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst;
  logic in_valid, in_ready, out_valid, out_ready;
  logic [31:0] in_prefix;
  logic [63:0] in_reg3, in_reg10, in_reg30;
  logic [4*N-1:0] in_cr;
  logic [N-1:0] out_enable;
  logic [23:0] out_remap;
  logic out_is_vec, out_illegal;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  vpm_unit #(.N(N)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_prefix(in_prefix), .in_reg3(in_reg3), .in_reg10(in_reg10),
    .in_reg30(in_reg30), .in_cr(in_cr), .out_valid(out_valid),
    .out_ready(out_ready), .out_enable(out_enable), .out_remap(out_remap),
    .out_is_vec(out_is_vec), .out_illegal(out_illegal)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // vector prefix from remap bits: bit6, 1, bit8, 1 around the opcode
  function automatic logic [31:0] mkvec(input logic [23:0] rm);
    return {6'b000001, rm[23], 1'b1, rm[22], 1'b1, rm[21:0]};
  endfunction

  function automatic logic [N-1:0] model(input logic [3:0] c);
    logic [N-1:0] e;
    for (int i = 0; i < N; i++) begin
      logic [3:0] f;
      f = in_cr[4*i +: 4];
      case (c)
        4'h0: e[i] = 1'b0;
        4'h1: e[i] = 1'b1;
        4'h2: e[i] = in_reg3[i];
        4'h3: e[i] = !in_reg3[i];
        4'h4: e[i] = in_reg10[i];
        4'h5: e[i] = !in_reg10[i];
        4'h6: e[i] = in_reg30[i];
        4'h7: e[i] = !in_reg30[i];
        4'h8: e[i] = f[3];
        4'h9: e[i] = !f[3];
        4'hA: e[i] = f[2];
        4'hB: e[i] = !f[2];
        4'hC: e[i] = f[1];
        4'hD: e[i] = !f[1];
        4'hE: e[i] = f[0];
        default: e[i] = !f[0];
      endcase
    end
    return e;
  endfunction

  task automatic send(input logic [31:0] w);
    @(negedge clk);
    in_prefix = w;
    in_valid  = 1'b1;
    @(negedge clk);
    in_valid  = 1'b0;
    check("R9 out_valid", out_valid, 1);
  endtask

  task automatic t_reset();
    check("R1 out_valid", out_valid, 0);
    check("R1 out_is_vec", out_is_vec, 0);
    check("R1 out_illegal", out_illegal, 0);
  endtask

  task automatic t_nonvec(input logic [31:0] w, input string tag);
    send(w);
    check({"R2 ", tag}, out_is_vec, 0);
    check("R4 enable", out_enable, {N{1'b1}});
    check("R4 remap", out_remap, 0);
    check("R4 illegal", out_illegal, 0);
  endtask

  task automatic t_code(input logic [3:0] c, input logic [19:0] low, input string req);
    logic [23:0] rm;
    rm = {c, low};
    send(mkvec(rm));
    check("R2 is_vec", out_is_vec, 1);
    check("R3 remap", out_remap, rm);
    check({req, " enable"}, out_enable, model(c));
    check("R5 illegal flag", out_illegal, c == 4'h0);
  endtask

  task automatic t_latency();
    send(mkvec({4'h1, 20'h0}));
    @(negedge clk);
    check("R9 drop", out_valid, 0);
  endtask

  task automatic t_backpressure();
    logic [23:0] ra, rb;
    ra = {4'h2, 20'hABCDE};
    rb = {4'h5, 20'h13579};
    @(negedge clk);
    out_ready = 1'b0;
    in_prefix = mkvec(ra);
    in_valid  = 1'b1;
    @(negedge clk);
    check("R10 first valid", out_valid, 1);
    check("R10 in_ready low", in_ready, 0);
    in_prefix = mkvec(rb);
    @(negedge clk);
    check("R10 held remap", out_remap, ra);
    check("R10 held enable", out_enable, model(4'h2));
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 next remap", out_remap, rb);
    check("R10 next enable", out_enable, model(4'h5));
    @(negedge clk);
    check("R10 drained", out_valid, 0);
    check("R10 empty ready", in_ready, 1);
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1; in_prefix = '0;
    in_reg3  = 64'h1234_0000_0000_00A5;
    in_reg10 = 64'hFFFF_0000_0000_003C;
    in_reg30 = 64'h0F0F_0000_0000_0081;
    for (int i = 0; i < N; i++) in_cr[4*i +: 4] = 4'((i * 7 + 3) & 15);
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_nonvec(32'h0000_0000, "opcode zero");
    t_nonvec(mkvec(24'h5A5A5A) ^ 32'h0100_0000, "bit7 clear");
    t_nonvec(mkvec(24'h5A5A5A) ^ 32'h0040_0000, "bit9 clear");
    t_nonvec(mkvec(24'h5A5A5A) ^ 32'h0800_0000, "opcode 3");
    t_code(4'h0, 20'h00000, "R5");
    t_code(4'h1, 20'hFFFFF, "R6");
    for (int c = 2; c < 8; c++) t_code(4'(c), 20'(c * 20'h1111), "R7");
    for (int c = 8; c < 16; c++) t_code(4'(c), 20'(c * 20'h0F0F), "R8");
    in_reg3 = ~in_reg3;
    in_cr = ~in_cr;
    t_code(4'h3, 20'h2C3D4, "R7");
    t_code(4'hA, 20'h80001, "R8");
    t_latency();
    t_backpressure();
    finish_run();
  end
endmodule